// File: doc/BRIEF.md
# UART Host Register Bank

This block is the processor-side register file of one serial channel. A host reaches it through a 3-bit address, an 8-bit write bus, an active-low channel select and single-cycle read and write strobes sampled on the rising clock edge. Writes land in control registers whose fields drive the transmitter, receiver, FIFO and interrupt logic of the channel. Reads return either a stored control byte or a status byte fed in from those neighbours, registered into `rdata`.

Several addresses are shared. At address 0 a read takes the receive byte and a write sends a transmit byte. At address 2 a read returns interrupt identification and a write sets up the FIFOs. When the bank-select bit (bit 7 of the line-control byte) is set, addresses 0 and 1 reach the two halves of the 16-bit baud divisor instead. Data-port traffic becomes one-cycle pop and push strobes to the FIFOs. The FIFO flush bits of the FIFO setup byte become one-cycle reset pulses and are not stored.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the interrupt-enable, line-control and modem-control bytes read 0x00, the scratch byte reads 0xFF, the divisor is 0x0000, all FIFO setup outputs are 0, and address 2 reads 0x01 when `irq_id` is 1.
- R2: With bank-select clear, a read of address 0 returns `rx_data` and pulses `rx_pop` for exactly one cycle. A write to address 0 puts the byte on `tx_data` and pulses `tx_push` for exactly one cycle.
- R3: With bank-select set, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. No pop or push occurs, and the interrupt-enable byte is left unchanged.
- R4: The interrupt-enable byte (address 1) keeps bits 5 and 3:0 of a write. Bits 7, 6 and 4 always read as 0.
- R5: A read of address 2 returns {fifo_en, fifo_en, 0, 0, irq_id[3:0]}, so bits 5 and 4 are always 0.
- R6: A write to address 2 sets `fifo_en_o` from bit 0, `dma_mode_o` from bit 3 and `rx_trig_o` from bits 7:6. Bit 1 and bit 2 give a one-cycle pulse on `rx_fifo_rst_o` and `tx_fifo_rst_o` respectively, in the cycle after the write.
- R7: The line-control byte (address 3) reads back as written. Its fields drive word length (1:0), extra stop bit (2), parity enable (3), even parity (4), forced parity (5), break (6), and bank-select (7).
- R8: The modem-control byte (address 4) keeps bits 7 and 4:0, and bits 6:5 read 0. Bit 0 drives `dtr_o`, bit 1 `rts_o`, bit 2 `aux_o`, bit 3 `irq_oe_o`, bit 4 `loop_o` and bit 7 `pwrdn_o`.
- R9: Addresses 5 and 6 read `lsr_in` and `msr_in` unchanged. Writes to them alter no register.
- R10: The scratch byte (address 7) reads back any value written.
- R11: While `cs_n` is high, strobes have no effect: no register changes, `rdata` holds its value, and no pop, push or flush pulse occurs.
- R12: `rdata` is updated at the edge that samples a read strobe and holds its value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Channel select, active low |
| rd_stb | input | 1 | Read strobe, one cycle |
| wr_stb | input | 1 | Write strobe, one cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_pop | output | 1 | Receive FIFO pop pulse |
| tx_data | output | 8 | Byte for the transmit FIFO |
| tx_push | output | 1 | Transmit FIFO push pulse |
| irq_id | input | 4 | Interrupt identification from interrupt logic |
| lsr_in | input | 8 | Line status byte |
| msr_in | input | 8 | Modem status byte |
| ier_o | output | 8 | Interrupt-enable byte |
| fifo_en_o | output | 1 | FIFO enable |
| dma_mode_o | output | 1 | DMA mode select |
| rx_trig_o | output | 2 | Receive trigger level code |
| rx_fifo_rst_o | output | 1 | Receive FIFO flush pulse |
| tx_fifo_rst_o | output | 1 | Transmit FIFO flush pulse |
| word_len_o | output | 2 | Word length code |
| stop_bits_o | output | 1 | Extra stop bit |
| par_en_o | output | 1 | Parity enable |
| par_even_o | output | 1 | Even parity |
| par_stick_o | output | 1 | Forced parity |
| brk_o | output | 1 | Break |
| divisor_o | output | 16 | Baud divisor |
| dtr_o | output | 1 | Modem-control bit 0 |
| rts_o | output | 1 | Modem-control bit 1 |
| aux_o | output | 1 | Modem-control bit 2 |
| irq_oe_o | output | 1 | Interrupt output enable |
| loop_o | output | 1 | Loopback mode |
| pwrdn_o | output | 1 | Power-down request |

## Verification
Control outputs take a written value at the edge that samples the write strobe. So the bench drives the strobe after one falling edge and checks the outputs at the next falling edge. `rdata`, `rx_pop`, `tx_push` and the flush pulses are also set at that same edge. The pulses are checked high at the first falling edge after the strobe and low at the following one, which shows they last exactly one cycle. Status inputs reach `rdata` only through a read, so each status check is made one edge after its read strobe.

// File: rtl/uart_host_regs_pkg.sv
package uart_host_regs_pkg;

    parameter int DW = 8;
    parameter int AW = 3;
    localparam int DIV_W   = 2 * DW;
    localparam int IRQ_W   = DW / 2;

    localparam logic [AW-1:0] A_DATA = 3'd0;
    localparam logic [AW-1:0] A_IER  = 3'd1;
    localparam logic [AW-1:0] A_FCR  = 3'd2;
    localparam logic [AW-1:0] A_LCR  = 3'd3;
    localparam logic [AW-1:0] A_MCR  = 3'd4;
    localparam logic [AW-1:0] A_LSR  = 3'd5;
    localparam logic [AW-1:0] A_MSR  = 3'd6;
    localparam logic [AW-1:0] A_SPR  = 3'd7;

    localparam logic [DW-1:0] IER_KEEP = 8'h2F;
    localparam logic [DW-1:0] MCR_KEEP = 8'h9F;
    localparam logic [DW-1:0] SPR_INIT = 8'hFF;
    localparam int            BANK_BIT = 7;

    typedef struct packed {
        logic thr;
        logic ier;
        logic fcr;
        logic lcr;
        logic mcr;
        logic spr;
        logic dll;
        logic dlm;
    } wsel_t;

    typedef enum logic [3:0] {
        RS_RHR, RS_IER, RS_ISR, RS_LCR, RS_MCR,
        RS_LSR, RS_MSR, RS_SPR, RS_DLL, RS_DLM
    } rsel_t;

    typedef struct packed {
        logic [DW-1:0]    ier;
        logic             fifo_en;
        logic             dma;
        logic [1:0]       trig;
        logic [DW-1:0]    lcr;
        logic [DW-1:0]    mcr;
        logic [DW-1:0]    spr;
        logic [DIV_W-1:0] div;
        logic [DW-1:0]    rdata;
        logic [DW-1:0]    txd;
        logic             push;
        logic             pop;
        logic             rxrst;
        logic             txrst;
    } state_t;

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
    import uart_host_regs_pkg::*;
(
    input  logic          sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic          bank,
    output wsel_t         wsel,
    output rsel_t         rsel,
    output logic          rd_hit
);

    always_comb begin
        wsel   = '0;
        rd_hit = sel && rd;
        unique case (addr)
            A_DATA:  rsel = bank ? RS_DLL : RS_RHR;
            A_IER:   rsel = bank ? RS_DLM : RS_IER;
            A_FCR:   rsel = RS_ISR;
            A_LCR:   rsel = RS_LCR;
            A_MCR:   rsel = RS_MCR;
            A_LSR:   rsel = RS_LSR;
            A_MSR:   rsel = RS_MSR;
            default: rsel = RS_SPR;
        endcase
        if (sel && wr) begin
            unique case (addr)
                A_DATA:  begin wsel.dll = bank; wsel.thr = !bank; end
                A_IER:   begin wsel.dlm = bank; wsel.ier = !bank; end
                A_FCR:   wsel.fcr = 1'b1;
                A_LCR:   wsel.lcr = 1'b1;
                A_MCR:   wsel.mcr = 1'b1;
                A_SPR:   wsel.spr = 1'b1;
                default: wsel = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_reg_rdmux.sv
module uart_reg_rdmux
    import uart_host_regs_pkg::*;
(
    input  rsel_t            rsel,
    input  logic [DW-1:0]    rx_data,
    input  logic [DW-1:0]    ier,
    input  logic             fifo_en,
    input  logic [IRQ_W-1:0] irq_id,
    input  logic [DW-1:0]    lcr,
    input  logic [DW-1:0]    mcr,
    input  logic [DW-1:0]    lsr_in,
    input  logic [DW-1:0]    msr_in,
    input  logic [DW-1:0]    spr,
    input  logic [DIV_W-1:0] div,
    output logic [DW-1:0]    rbyte
);

    logic [DW-1:0] isr_byte;

    always_comb begin
        isr_byte = {fifo_en, fifo_en, 2'b00, irq_id};
        unique case (rsel)
            RS_RHR:  rbyte = rx_data;
            RS_IER:  rbyte = ier;
            RS_ISR:  rbyte = isr_byte;
            RS_LCR:  rbyte = lcr;
            RS_MCR:  rbyte = mcr;
            RS_LSR:  rbyte = lsr_in;
            RS_MSR:  rbyte = msr_in;
            RS_SPR:  rbyte = spr;
            RS_DLL:  rbyte = div[DW-1:0];
            RS_DLM:  rbyte = div[DIV_W-1:DW];
            default: rbyte = '0;
        endcase
    end

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_host_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [DW-1:0]    rx_data,
    output logic             rx_pop,
    output logic [DW-1:0]    tx_data,
    output logic             tx_push,
    input  logic [IRQ_W-1:0] irq_id,
    input  logic [DW-1:0]    lsr_in,
    input  logic [DW-1:0]    msr_in,
    output logic [DW-1:0]    ier_o,
    output logic             fifo_en_o,
    output logic             dma_mode_o,
    output logic [1:0]       rx_trig_o,
    output logic             rx_fifo_rst_o,
    output logic             tx_fifo_rst_o,
    output logic [1:0]       word_len_o,
    output logic             stop_bits_o,
    output logic             par_en_o,
    output logic             par_even_o,
    output logic             par_stick_o,
    output logic             brk_o,
    output logic [DIV_W-1:0] divisor_o,
    output logic             dtr_o,
    output logic             rts_o,
    output logic             aux_o,
    output logic             irq_oe_o,
    output logic             loop_o,
    output logic             pwrdn_o
);

    state_t        st_d, st_q;
    wsel_t         wsel;
    rsel_t         rsel;
    logic          rd_hit;
    logic [DW-1:0] rbyte;
    logic          dlab_q;
    logic [DW-1:0] lcr_q;

    assign dlab_q = st_q.lcr[BANK_BIT];
    assign lcr_q  = st_q.lcr;

    uart_reg_decode i_decode (
        .sel    (!cs_n),
        .rd     (rd_stb),
        .wr     (wr_stb),
        .addr   (addr),
        .bank   (dlab_q),
        .wsel   (wsel),
        .rsel   (rsel),
        .rd_hit (rd_hit)
    );

    uart_reg_rdmux i_rdmux (
        .rsel    (rsel),
        .rx_data (rx_data),
        .ier     (st_q.ier),
        .fifo_en (st_q.fifo_en),
        .irq_id  (irq_id),
        .lcr     (st_q.lcr),
        .mcr     (st_q.mcr),
        .lsr_in  (lsr_in),
        .msr_in  (msr_in),
        .spr     (st_q.spr),
        .div     (st_q.div),
        .rbyte   (rbyte)
    );

    always_comb begin
        st_d       = st_q;
        st_d.push  = 1'b0;
        st_d.pop   = 1'b0;
        st_d.rxrst = 1'b0;
        st_d.txrst = 1'b0;
        if (wsel.thr) begin
            st_d.txd  = wdata;
            st_d.push = 1'b1;
        end
        if (wsel.ier) st_d.ier = wdata & IER_KEEP;
        if (wsel.fcr) begin
            st_d.fifo_en = wdata[0];
            st_d.rxrst   = wdata[1];
            st_d.txrst   = wdata[2];
            st_d.dma     = wdata[3];
            st_d.trig    = wdata[7:6];
        end
        if (wsel.lcr) st_d.lcr = wdata;
        if (wsel.mcr) st_d.mcr = wdata & MCR_KEEP;
        if (wsel.spr) st_d.spr = wdata;
        if (wsel.dll) st_d.div[DW-1:0]     = wdata;
        if (wsel.dlm) st_d.div[DIV_W-1:DW] = wdata;
        if (rd_hit) begin
            st_d.rdata = rbyte;
            st_d.pop   = (rsel == RS_RHR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.spr <= SPR_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata         = st_q.rdata;
    assign rx_pop        = st_q.pop;
    assign tx_data       = st_q.txd;
    assign tx_push       = st_q.push;
    assign ier_o         = st_q.ier;
    assign fifo_en_o     = st_q.fifo_en;
    assign dma_mode_o    = st_q.dma;
    assign rx_trig_o     = st_q.trig;
    assign rx_fifo_rst_o = st_q.rxrst;
    assign tx_fifo_rst_o = st_q.txrst;
    assign word_len_o    = st_q.lcr[1:0];
    assign stop_bits_o   = st_q.lcr[2];
    assign par_en_o      = st_q.lcr[3];
    assign par_even_o    = st_q.lcr[4];
    assign par_stick_o   = st_q.lcr[5];
    assign brk_o         = st_q.lcr[6];
    assign divisor_o     = st_q.div;
    assign dtr_o         = st_q.mcr[0];
    assign rts_o         = st_q.mcr[1];
    assign aux_o         = st_q.mcr[2];
    assign irq_oe_o      = st_q.mcr[3];
    assign loop_o        = st_q.mcr[4];
    assign pwrdn_o       = st_q.mcr[7];

endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk
    import uart_host_regs_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_stb,
    input logic          wr_stb,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          dlab,
    input logic [DW-1:0] lcr,
    input logic          rx_pop,
    input logic          tx_push,
    input logic          rx_fifo_rst,
    input logic          tx_fifo_rst
);

    // R2: a pop only follows an accepted data-port read in the data bank
    a_r2_pop_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(!cs_n && rd_stb && addr == A_DATA && !dlab));

    // R2, R3: a push only follows a data-port write with bank-select clear
    a_r3_push_source: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(!cs_n && wr_stb && addr == A_DATA && !dlab));

    // R6: flush pulses only follow a FIFO setup write with the matching bit
    a_r6_rx_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_rst |-> $past(!cs_n && wr_stb && addr == A_FCR && wdata[1]));

    a_r6_tx_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_rst |-> $past(!cs_n && wr_stb && addr == A_FCR && wdata[2]));

    // R11: nothing fires after a deselected cycle
    a_r11_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !(rx_pop || tx_push || rx_fifo_rst || tx_fifo_rst));

    // R7: line-control byte only changes after a write to its address
    a_r7_lcr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!cs_n && wr_stb && addr == A_LCR) |-> $stable(lcr));

endmodule

bind uart_host_regs uart_host_regs_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .addr        (addr),
    .wdata       (wdata),
    .dlab        (dlab_q),
    .lcr         (lcr_q),
    .rx_pop      (rx_pop),
    .tx_push     (tx_push),
    .rx_fifo_rst (rx_fifo_rst_o),
    .tx_fifo_rst (tx_fifo_rst_o)
);

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_pop;
    logic [7:0]  tx_data;
    logic        tx_push;
    logic [3:0]  irq_id = 4'h1;
    logic [7:0]  lsr_in = 8'h60;
    logic [7:0]  msr_in = 8'h00;
    logic [7:0]  ier_o;
    logic        fifo_en_o, dma_mode_o, rx_fifo_rst_o, tx_fifo_rst_o;
    logic [1:0]  rx_trig_o, word_len_o;
    logic        stop_bits_o, par_en_o, par_even_o, par_stick_o, brk_o;
    logic [15:0] divisor_o;
    logic        dtr_o, rts_o, aux_o, irq_oe_o, loop_o, pwrdn_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    uart_host_regs i_uart_host_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rx_data(rx_data),
        .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push), .irq_id(irq_id),
        .lsr_in(lsr_in), .msr_in(msr_in), .ier_o(ier_o), .fifo_en_o(fifo_en_o),
        .dma_mode_o(dma_mode_o), .rx_trig_o(rx_trig_o),
        .rx_fifo_rst_o(rx_fifo_rst_o), .tx_fifo_rst_o(tx_fifo_rst_o),
        .word_len_o(word_len_o), .stop_bits_o(stop_bits_o), .par_en_o(par_en_o),
        .par_even_o(par_even_o), .par_stick_o(par_stick_o), .brk_o(brk_o),
        .divisor_o(divisor_o), .dtr_o(dtr_o), .rts_o(rts_o), .aux_o(aux_o),
        .irq_oe_o(irq_oe_o), .loop_o(loop_o), .pwrdn_o(pwrdn_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // strobe driven after a falling edge; results sampled at the next one
    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic sel = 1'b1);
        cs_n = !sel; wr_stb = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic sel = 1'b1);
        cs_n = !sel; rd_stb = 1'b1; addr = a;
        @(negedge clk);
        cs_n = 1'b1; rd_stb = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd1); chk("R1 ier", rdata, 8'h00);
        rd(3'd3); chk("R1 lcr", rdata, 8'h00);
        rd(3'd4); chk("R1 mcr", rdata, 8'h00);
        rd(3'd7); chk("R1 spr", rdata, 8'hFF);
        rd(3'd2); chk("R1 isr", rdata, 8'h01);
        rd(3'd5); chk("R1 lsr", rdata, 8'h60);
        chk("R1 divisor", divisor_o, 16'h0000);
        chk("R1 fifo outs", {fifo_en_o, dma_mode_o, rx_trig_o, rx_fifo_rst_o, tx_fifo_rst_o}, 0);

        // R10 scratch exhaustive
        for (int v = 0; v < 256; v++) begin
            wr(3'd7, 8'(v)); rd(3'd7);
            chk("R10 scratch", rdata, 16'(v));
        end

        // R4 interrupt enable exhaustive
        for (int v = 0; v < 256; v++) begin
            wr(3'd1, 8'(v)); rd(3'd1);
            chk("R4 ier read", rdata, 16'(v & 8'h2F));
            chk("R4 ier out", ier_o, 16'(v & 8'h2F));
        end

        // R8 modem control exhaustive
        for (int v = 0; v < 256; v++) begin
            logic [7:0] m;
            m = 8'(v) & 8'h9F;
            wr(3'd4, 8'(v)); rd(3'd4);
            chk("R8 mcr read", rdata, 16'(m));
            chk("R8 mcr outs", {pwrdn_o, loop_o, irq_oe_o, aux_o, rts_o, dtr_o},
                {m[7], m[4], m[3], m[2], m[1], m[0]});
        end

        // R7 line control exhaustive
        for (int v = 0; v < 256; v++) begin
            logic [7:0] l;
            l = 8'(v);
            wr(3'd3, l); rd(3'd3);
            chk("R7 lcr read", rdata, 16'(l));
            chk("R7 lcr fields", {brk_o, par_stick_o, par_even_o, par_en_o, stop_bits_o, word_len_o},
                16'(l[6:0]));
        end
        wr(3'd3, 8'h03);

        // R6 FIFO setup exhaustive, pulse high one cycle then low
        for (int v = 0; v < 256; v++) begin
            logic [7:0] f;
            f = 8'(v);
            wr(3'd2, f);
            chk("R6 fifo outs", {rx_trig_o, dma_mode_o, fifo_en_o}, {f[7:6], f[3], f[0]});
            chk("R6 flush pulse", {tx_fifo_rst_o, rx_fifo_rst_o}, 16'(f[2:1]));
            @(negedge clk);
            chk("R6 flush one cycle", {tx_fifo_rst_o, rx_fifo_rst_o}, 0);
        end

        // R5 interrupt status under both FIFO states
        for (int fe = 0; fe < 2; fe++) begin
            wr(3'd2, 8'(fe));
            for (int id = 0; id < 16; id++) begin
                irq_id = 4'(id);
                rd(3'd2);
                chk("R5 isr", rdata, 16'({fe[0], fe[0], 2'b00, 4'(id)}));
            end
        end
        irq_id = 4'h1;

        // R9 status pass-through, writes ignored
        for (int v = 0; v < 256; v += 17) begin
            lsr_in = 8'(v); msr_in = 8'(255 - v);
            rd(3'd5); chk("R9 lsr", rdata, 16'(v));
            rd(3'd6); chk("R9 msr", rdata, 16'(255 - v));
        end
        wr(3'd7, 8'h5A); wr(3'd1, 8'h21); wr(3'd4, 8'h11);
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
        rd(3'd7); chk("R9 spr unchanged", rdata, 8'h5A);
        rd(3'd1); chk("R9 ier unchanged", rdata, 8'h21);
        rd(3'd4); chk("R9 mcr unchanged", rdata, 8'h11);

        // R2 data port, several bytes
        for (int v = 0; v < 256; v += 51) begin
            rx_data = 8'(v ^ 8'hA5);
            rd(3'd0);
            chk("R2 rx byte", rdata, 16'(v ^ 8'hA5));
            chk("R2 pop high", rx_pop, 1);
            @(negedge clk);
            chk("R2 pop one cycle", rx_pop, 0);
            wr(3'd0, 8'(v));
            chk("R2 tx byte", tx_data, 16'(v));
            chk("R2 push high", tx_push, 1);
            @(negedge clk);
            chk("R2 push one cycle", tx_push, 0);
        end

        // R3 divisor bank
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34);
        chk("R3 no push", tx_push, 0);
        wr(3'd1, 8'h12);
        chk("R3 divisor", divisor_o, 16'h1234);
        chk("R3 ier kept", ier_o, 8'h21);
        rx_data = 8'hEE;
        rd(3'd0); chk("R3 dll read", rdata, 8'h34); chk("R3 no pop", rx_pop, 0);
        rd(3'd1); chk("R3 dlm read", rdata, 8'h12);
        wr(3'd0, 8'hCD); wr(3'd1, 8'hAB);
        chk("R3 divisor 2", divisor_o, 16'hABCD);
        wr(3'd3, 8'h03);
        rd(3'd1); chk("R3 ier after bank", rdata, 8'h21);
        chk("R3 divisor kept", divisor_o, 16'hABCD);

        // R11 deselected strobes
        rd(3'd7); chk("R11 pre read", rdata, 8'h5A);
        wr(3'd7, 8'h00, 1'b0);
        wr(3'd0, 8'h77, 1'b0);
        chk("R11 no push", tx_push, 0);
        wr(3'd2, 8'h06, 1'b0);
        chk("R11 no flush", {tx_fifo_rst_o, rx_fifo_rst_o}, 0);
        rd(3'd0, 1'b0);
        chk("R11 no pop", rx_pop, 0);
        chk("R11 rdata held", rdata, 8'h5A);
        rd(3'd7); chk("R11 spr unchanged", rdata, 8'h5A);

        // R12 read data holds between reads
        rd(3'd4);
        repeat (5) @(negedge clk);
        chk("R12 rdata hold", rdata, 8'h11);
        wr(3'd4, 8'h00);
        chk("R12 rdata not from write", rdata, 8'h11);

        done = 1;
        summary();
    end

endmodule